// File: doc/BRIEF.md
# Wide-Bus Master Width Negotiator

This block sits in the master side of a bus whose address and data share 64 wires, split into a lower and an upper 32-bit half. For each transaction it raises a 64-bit transfer request alongside the framing signal. It picks a single or a dual address phase from the target address. It then learns from the target's device-select response whether the target takes full quadwords. The master core supplies a stream of 64-bit words with byte enables. The block either sends each word whole, or splits it into two lower-lane dwords when the target is narrow.

The block drives the upper address/data lanes, the upper command/byte-enable lanes and the upper-half parity. Each of these has an output-enable, so the pad ring can float them once a narrow target is known. It runs its own small phase sequencer: idle, address, optional second address, data. It drives the framing, request and initiator-ready strobes from that sequencer. Only write-direction data phases are modelled. The target's device-select, target-ready and 64-bit acknowledge come in as active-low inputs.

Top module: `wide_lane_negotiator`

## Requirements
- R1: `req64_n` equals `frame_n` in every cycle, both active low and idle high.
- R2: If `addr[63:32]` is zero there is one address phase with `ad_lo`=`addr[31:0]`, `cbe_lo_n`=`cmd`, `ad_hi`=0, `cbe_hi_n`=0. Otherwise there are two phases. The first has `ad_lo`=`addr[31:0]`, `cbe_lo_n`=4'b1101, `ad_hi`=`addr[63:32]`, `cbe_hi_n`=`cmd`. The second has `ad_lo`=`ad_hi`=`addr[63:32]` and `cbe_lo_n`=`cbe_hi_n`=`cmd`.
- R3: `ack64_n` is sampled at the first clock edge of the data period where `devsel_n` is low. `irdy_n` stays high until the clock after that edge. The width found there holds until the transaction ends.
- R4: With a wide target, each data phase drives `ad_lo`=word[31:0], `ad_hi`=word[63:32], `cbe_lo_n`=~be[3:0] and `cbe_hi_n`=~be[7:4], where be is active high.
- R5: With a narrow target, each word goes out on `ad_lo` with the lower dword first and then the upper. `cbe_lo_n` is the inverse of the matching half of be. A half with all enables off is skipped, except that a word with no enables at all still sends its lower half.
- R6: With a narrow target, `ad_hi_oe` is low during data phases. `par64_oe` is high exactly one clock after `ad_hi_oe` was high.
- R7: When `par64_oe` is high, `par64` is the XOR of `ad_hi` and `cbe_hi_n` from the previous clock, which gives even parity over those 37 bits.
- R8: `frame_n` and `req64_n` go high in the final data phase while `irdy_n` is low. After the final transfer, `frame_n`, `req64_n` and `irdy_n` are high and `ad_lo_oe`/`ad_hi_oe` are low. This is also the state out of reset.
- R9: `start` is ignored while a transaction is under way.
- R10: A data phase completes only on a clock where both `irdy_n` and `trdy_n` are low. `wd_pop` pulses in the phase that finishes the current word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transaction (taken only when idle) |
| addr | input | 64 | Target byte address |
| cmd | input | 4 | Bus command |
| wd_data | input | 64 | Current write word |
| wd_be | input | 8 | Byte enables of current word, active high |
| wd_last | input | 1 | Current word is the last one |
| wd_pop | output | 1 | Current word consumed this clock |
| frame_n | output | 1 | Transaction framing, active low |
| req64_n | output | 1 | 64-bit transfer request, active low |
| irdy_n | output | 1 | Initiator ready, active low |
| devsel_n | input | 1 | Target claimed the transaction, active low |
| trdy_n | input | 1 | Target ready, active low |
| ack64_n | input | 1 | Target accepts 64-bit transfers, active low |
| ad_lo | output | 32 | Lower address/data lanes |
| cbe_lo_n | output | 4 | Lower command/byte-enable lanes |
| ad_lo_oe | output | 1 | Drive enable for lower lanes |
| ad_hi | output | 32 | Upper address/data lanes |
| cbe_hi_n | output | 4 | Upper command/byte-enable lanes |
| ad_hi_oe | output | 1 | Drive enable for upper lanes |
| par64 | output | 1 | Upper-half parity |
| par64_oe | output | 1 | Drive enable for upper-half parity |

## Verification
The bench aims at addresses just below and exactly at the 4 GB line. A design with the wrong comparison there would pick the wrong address-phase count and misplace the dual-address command code. For narrow targets it sends words whose enables cover only the lower half, only the upper half, both halves, or neither. A broken skip rule would put an empty dword on the bus, drop a live one, or end framing one phase early or late. It varies how long the target takes to claim the transaction and adds wait states. A design that sampled the width late or early, or let a phase advance without target ready, would show wrong lanes or a lost pop. It also pulses `start` in the middle of a data period, so a design that took the pulse would restart with a fresh address phase.

// File: rtl/wide_lane_negotiator.sv
module wide_lane_negotiator #(
  parameter logic [3:0] DAC_CMD = 4'b1101
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] addr,
  input  logic [3:0]  cmd,
  input  logic [63:0] wd_data,
  input  logic [7:0]  wd_be,
  input  logic        wd_last,
  output logic        wd_pop,
  output logic        frame_n,
  output logic        req64_n,
  output logic        irdy_n,
  input  logic        devsel_n,
  input  logic        trdy_n,
  input  logic        ack64_n,
  output logic [31:0] ad_lo,
  output logic [3:0]  cbe_lo_n,
  output logic        ad_lo_oe,
  output logic [31:0] ad_hi,
  output logic [3:0]  cbe_hi_n,
  output logic        ad_hi_oe,
  output logic        par64,
  output logic        par64_oe
);

  typedef enum logic [1:0] {S_IDLE, S_ADR1, S_ADR2, S_DATA} phase_t;

  phase_t      st;
  logic [63:0] addr_q;
  logic [3:0]  cmd_q;
  logic        dual_q, known_q, wide_q, hi_sel_q;
  logic        par_q, par_oe_q;

  wire in_data  = st == S_DATA;
  wire go       = in_data && known_q;
  wire lo_need  = (wd_be[3:0] != 4'h0) || (wd_be[7:4] == 4'h0);
  wire hi_need  = wd_be[7:4] != 4'h0;
  wire sel_hi   = hi_sel_q || !lo_need;
  wire adv_half = !wide_q && !sel_hi && hi_need;
  wire last_ph  = wd_last && (wide_q || sel_hi || !hi_need);
  wire xfer     = go && !trdy_n;
  wire framing  = (st == S_ADR1) || (st == S_ADR2) || (in_data && !(go && last_ph));

  assign frame_n  = !framing;
  assign req64_n  = !framing;
  assign irdy_n   = !go;
  assign wd_pop   = xfer && !adv_half;
  assign ad_lo_oe = st != S_IDLE;
  assign ad_hi_oe = (st == S_ADR1) || (st == S_ADR2) || (in_data && (!known_q || wide_q));
  assign par64    = par_q;
  assign par64_oe = par_oe_q;

  always_comb begin
    ad_lo    = 32'h0;
    cbe_lo_n = 4'hF;
    ad_hi    = 32'h0;
    cbe_hi_n = 4'hF;
    unique case (st)
      S_ADR1: begin
        ad_lo    = addr_q[31:0];
        cbe_lo_n = dual_q ? DAC_CMD : cmd_q;
        ad_hi    = dual_q ? addr_q[63:32] : 32'h0;
        cbe_hi_n = dual_q ? cmd_q : 4'h0;
      end
      S_ADR2: begin
        ad_lo    = addr_q[63:32];
        cbe_lo_n = cmd_q;
        ad_hi    = addr_q[63:32];
        cbe_hi_n = cmd_q;
      end
      S_DATA: begin
        if (go && !wide_q) begin
          ad_lo    = sel_hi ? wd_data[63:32] : wd_data[31:0];
          cbe_lo_n = ~(sel_hi ? wd_be[7:4] : wd_be[3:0]);
        end else begin
          ad_lo    = wd_data[31:0];
          cbe_lo_n = ~wd_be[3:0];
          ad_hi    = wd_data[63:32];
          cbe_hi_n = ~wd_be[7:4];
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr_q   <= 64'h0;
      cmd_q    <= 4'h0;
      dual_q   <= 1'b0;
      known_q  <= 1'b0;
      wide_q   <= 1'b0;
      hi_sel_q <= 1'b0;
      par_q    <= 1'b0;
      par_oe_q <= 1'b0;
    end else begin
      par_q    <= ^{ad_hi, cbe_hi_n};
      par_oe_q <= ad_hi_oe;
      unique case (st)
        S_IDLE: if (start) begin
          addr_q <= addr;
          cmd_q  <= cmd;
          dual_q <= addr[63:32] != 32'h0;
          st     <= S_ADR1;
        end
        S_ADR1: st <= dual_q ? S_ADR2 : S_DATA;
        S_ADR2: st <= S_DATA;
        S_DATA: begin
          if (!known_q && !devsel_n) begin
            known_q <= 1'b1;
            wide_q  <= !ack64_n;
          end
          if (xfer) begin
            hi_sel_q <= adv_half;
            if (last_ph) begin
              st      <= S_IDLE;
              known_q <= 1'b0;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wln_props.sv
module wln_props (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_n,
  input logic        irdy_n,
  input logic        devsel_n,
  input logic        trdy_n,
  input logic        wd_pop,
  input logic [31:0] ad_hi,
  input logic [3:0]  cbe_lo_n,
  input logic [3:0]  cbe_hi_n,
  input logic        ad_hi_oe,
  input logic        par64,
  input logic        par64_oe
);

  p_addr_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |-> ((cbe_lo_n == 4'b1101) == (ad_hi != 32'h0)));

  p_irdy_after_claim_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irdy_n) |-> $past(!devsel_n));

  p_width_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && $past(!irdy_n)) |-> (ad_hi_oe == $past(ad_hi_oe)));

  p_par_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ad_hi_oe |=> !par64_oe);

  p_par_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ad_hi_oe |=> (par64_oe && (par64 == ^$past({ad_hi, cbe_hi_n}))));

  p_frame_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_n) |-> !irdy_n);

  p_pop_handshake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wd_pop |-> (!irdy_n && !trdy_n));

endmodule

bind wide_lane_negotiator wln_props u_props (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
  .devsel_n(devsel_n), .trdy_n(trdy_n), .wd_pop(wd_pop), .ad_hi(ad_hi),
  .cbe_lo_n(cbe_lo_n), .cbe_hi_n(cbe_hi_n), .ad_hi_oe(ad_hi_oe),
  .par64(par64), .par64_oe(par64_oe)
);

// File: tb/wide_lane_negotiator_test.sv
module wide_lane_negotiator_test;
  localparam int CLK_NS = 10;

  typedef struct packed {
    logic [63:0] a;
    logic [3:0]  c;
    logic        wide;
    logic [1:0]  nw;
    logic [7:0]  b0, b1, b2;
    logic [1:0]  dly;
    logic        wt;
  } vec_t;

  localparam vec_t VT [8] = '{
    '{64'h0000_0000_1000_0040, 4'h7, 1'b1, 2'd2, 8'hFF, 8'hFF, 8'h00, 2'd0, 1'b0},
    '{64'h0000_0002_0000_0100, 4'h7, 1'b1, 2'd3, 8'h0F, 8'hF0, 8'hFF, 2'd1, 1'b1},
    '{64'h0000_0000_2000_0000, 4'h7, 1'b0, 2'd2, 8'hFF, 8'hFF, 8'h00, 2'd0, 1'b0},
    '{64'h0000_0001_0000_0000, 4'h7, 1'b0, 2'd3, 8'hF0, 8'h0F, 8'h3C, 2'd2, 1'b1},
    '{64'h0000_0000_FFFF_FFF8, 4'h3, 1'b0, 2'd1, 8'h00, 8'h00, 8'h00, 2'd1, 1'b0},
    '{64'hFFFF_FFFF_0000_0000, 4'h7, 1'b1, 2'd1, 8'h81, 8'h00, 8'h00, 2'd3, 1'b0},
    '{64'h0000_0000_0000_1000, 4'h7, 1'b0, 2'd1, 8'h80, 8'h00, 8'h00, 2'd0, 1'b1},
    '{64'h0000_0000_3000_0008, 4'h3, 1'b1, 2'd3, 8'h00, 8'hFF, 8'h18, 2'd1, 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic start = 0, wd_last = 0, devsel_n = 1, trdy_n = 1, ack64_n = 1;
  logic [63:0] addr = '0, wd_data = '0;
  logic [3:0] cmd = '0;
  logic [7:0] wd_be = '0;
  logic wd_pop, frame_n, req64_n, irdy_n, ad_lo_oe, ad_hi_oe, par64, par64_oe;
  logic [31:0] ad_lo, ad_hi;
  logic [3:0] cbe_lo_n, cbe_hi_n;
  int n_chk = 0, n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  wide_lane_negotiator uut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [63:0] wdat(int vi, int w);
    return {16'hA5A5 ^ 16'(vi), 16'(w), 16'h5A00 ^ 16'(vi), 16'(w + 16)};
  endfunction

  function automatic logic [7:0] wbe(vec_t v, int w);
    return (w == 0) ? v.b0 : (w == 1) ? v.b1 : v.b2;
  endfunction

  // parity follows the upper lanes by one clock
  logic prev_ok = 0, prev_oe = 0;
  logic [35:0] prev_bits = '0;
  always @(negedge clk) begin
    #4;
    if (!rst_n) prev_ok = 0;
    else begin
      if (prev_ok) begin
        chk(par64_oe == prev_oe, "R6 parity enable", 64'(par64_oe), 64'(prev_oe));
        if (prev_oe) chk(par64 == ^prev_bits, "R7 parity value", 64'(par64), 64'(^prev_bits));
      end
      prev_ok = 1;
      prev_oe = ad_hi_oe;
      prev_bits = {ad_hi, cbe_hi_n};
    end
  end

  task automatic run_txn(input vec_t v, input int vi);
    logic [31:0] elo [6];
    logic [3:0]  eclo [6];
    logic [31:0] ehi [6];
    logic [3:0]  echi [6];
    bit          epop [6];
    int nph = 0, w = 0, k = 0, c = 0;
    bit known = 0, done = 0, dual;
    string tag;
    for (int i = 0; i < int'(v.nw); i++) begin
      logic [63:0] d = wdat(vi, i);
      logic [7:0] b = wbe(v, i);
      bit lo_n = (b[3:0] != 0) || (b[7:4] == 0);
      bit hi_n = b[7:4] != 0;
      if (v.wide) begin
        elo[nph] = d[31:0]; eclo[nph] = ~b[3:0]; ehi[nph] = d[63:32]; echi[nph] = ~b[7:4];
        epop[nph] = 1; nph++;
      end else begin
        if (lo_n) begin
          elo[nph] = d[31:0]; eclo[nph] = ~b[3:0]; epop[nph] = !hi_n; nph++;
        end
        if (hi_n) begin
          elo[nph] = d[63:32]; eclo[nph] = ~b[7:4]; epop[nph] = 1; nph++;
        end
      end
    end
    tag = v.wide ? "R4 wide lanes" : "R5 narrow lanes";
    dual = v.a[63:32] != 0;

    @(negedge clk);
    start = 1; addr = v.a; cmd = v.c;
    wd_data = wdat(vi, 0); wd_be = wbe(v, 0); wd_last = (v.nw == 1);
    #1 chk(frame_n == 1, "R8 idle before start", 64'(frame_n), 64'd1);
    @(negedge clk);
    start = 0;
    #1;
    chk(frame_n == 0, "R2 framing in address", 64'(frame_n), 64'd0);
    chk(req64_n == frame_n, "R1 request mirrors framing", 64'(req64_n), 64'(frame_n));
    chk(ad_lo == v.a[31:0], "R2 first address low", 64'(ad_lo), 64'(v.a[31:0]));
    chk(cbe_lo_n == (dual ? 4'hD : v.c), "R2 first command", 64'(cbe_lo_n), 64'(dual ? 4'hD : v.c));
    chk(ad_hi == (dual ? v.a[63:32] : 32'h0), "R2 first address high", 64'(ad_hi), 64'(dual ? v.a[63:32] : 32'h0));
    chk(cbe_hi_n == (dual ? v.c : 4'h0), "R2 upper command", 64'(cbe_hi_n), 64'(dual ? v.c : 4'h0));
    if (dual) begin
      @(negedge clk);
      #1;
      chk(ad_lo == v.a[63:32], "R2 second address", 64'(ad_lo), 64'(v.a[63:32]));
      chk(cbe_lo_n == v.c, "R2 second command", 64'(cbe_lo_n), 64'(v.c));
      chk(req64_n == frame_n && frame_n == 0, "R1 request in second address", 64'(req64_n), 64'd0);
    end

    while (!done) begin
      bit known_nx;
      @(negedge clk);
      if (w < int'(v.nw)) begin
        wd_data = wdat(vi, w); wd_be = wbe(v, w); wd_last = (w == int'(v.nw) - 1);
      end
      devsel_n = (c < int'(v.dly)) ? 1'b1 : 1'b0;
      ack64_n  = (!devsel_n && v.wide) ? 1'b0 : 1'b1;
      trdy_n   = (known && !(v.wt && c[0])) ? 1'b0 : 1'b1;
      start    = (c == 1);  // R9: must be ignored mid-transaction
      #1;
      known_nx = known || !devsel_n;
      chk(req64_n == frame_n, "R1 request mirrors framing", 64'(req64_n), 64'(frame_n));
      chk(irdy_n == !known, "R3 ready waits for width", 64'(irdy_n), 64'(!known));
      if (known) begin
        chk(ad_lo == elo[k], tag, 64'(ad_lo), 64'(elo[k]));
        chk(cbe_lo_n == eclo[k], tag, 64'(cbe_lo_n), 64'(eclo[k]));
        chk(ad_hi_oe == v.wide, "R6 upper lane enable", 64'(ad_hi_oe), 64'(v.wide));
        if (v.wide) begin
          chk(ad_hi == ehi[k], "R4 upper data", 64'(ad_hi), 64'(ehi[k]));
          chk(cbe_hi_n == echi[k], "R4 upper enables", 64'(cbe_hi_n), 64'(echi[k]));
        end
        chk(frame_n == (k == nph - 1), "R8 framing release", 64'(frame_n), 64'(k == nph - 1));
        if (!trdy_n) begin
          chk(wd_pop == epop[k], "R10 pop on completion", 64'(wd_pop), 64'(epop[k]));
          if (epop[k]) w++;
          if (k == nph - 1) done = 1;
          k++;
        end else begin
          chk(wd_pop == 0, "R10 no pop in wait state", 64'(wd_pop), 64'd0);
        end
      end
      known = known_nx;
      c++;
      if (c > 40) begin
        chk(0, "R10 transaction stalled", 64'(c), 64'(nph));
        done = 1;
      end
    end

    @(negedge clk);
    devsel_n = 1; trdy_n = 1; ack64_n = 1; start = 0;
    #1;
    chk(frame_n && req64_n && irdy_n, "R8 strobes idle after end", {61'd0, frame_n, req64_n, irdy_n}, 64'd7);
    chk(!ad_lo_oe && !ad_hi_oe, "R9 R8 lanes released", {62'd0, ad_lo_oe, ad_hi_oe}, 64'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog expired actual=hung expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(frame_n && req64_n && irdy_n, "R8 reset strobes", {61'd0, frame_n, req64_n, irdy_n}, 64'd7);
    chk(!ad_lo_oe && !ad_hi_oe && !par64_oe, "R8 reset enables", {61'd0, ad_lo_oe, ad_hi_oe, par64_oe}, 64'd0);
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 8; i++) run_txn(VT[i], i);

    // R9: start pulse while idle is taken, a second one during address is not
    @(negedge clk);
    start = 1; addr = 64'h40; cmd = 4'h7; wd_data = wdat(9, 0); wd_be = 8'hFF; wd_last = 1;
    @(negedge clk);
    addr = 64'h0000_0005_0000_0000;
    #1 chk(ad_lo == 32'h40 && cbe_lo_n == 4'h7, "R9 first request kept", 64'(ad_lo), 64'h40);
    @(negedge clk);
    start = 0; devsel_n = 0; ack64_n = 0;
    #1 chk(irdy_n == 1 && frame_n == 0, "R9 no restart in data", 64'(frame_n), 64'd0);
    @(negedge clk);
    trdy_n = 0;
    #1 chk(frame_n == 1 && irdy_n == 0 && wd_pop == 1, "R8 single wide phase", {61'd0, frame_n, irdy_n, wd_pop}, 64'd5);
    @(negedge clk);
    devsel_n = 1; ack64_n = 1; trdy_n = 1;
    #1 chk(frame_n && !ad_lo_oe, "R9 idle after single phase", 64'(frame_n), 64'd1);
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule